// File: doc/BRIEF.md
# Half-Step Memory Clock Divider

This block derives a memory clock from the core clock, dividing it by a ratio chosen from 2 to 5 in steps of one half. A half-integer ratio gives an output period that is not a whole number of core cycles. The block therefore times its output in core half-cycles. A schedule register in the rising-edge domain works out the wanted output level for both halves of each core cycle. A pair of flops, one clocked on each edge, turns that plan into an output that is exact to the half-cycle and free of glitches. The output is driven onto several identical copies for the memory devices.

The ratio select is a plain control input, sampled by the core clock. It carries no data stream, so it has no handshake. A new code is taken only where one output period ends and the next begins. The period in progress always completes with its old length, so a change never produces a runt pulse. After reset the output is low and the first period uses ratio 4, whatever the select input shows.

Top module: `halfstep_clkdiv`

## Requirements
- R1: While rst_n is low, every output copy is low. Asserting rst_n forces the outputs low at once, without waiting for a clock edge.
- R2: All NUM_OUT output copies carry the same level at all times.
- R3: A select code c from 0 to 6 gives an output period of 4 + c core half-cycles, which is a ratio of 2 + c/2.
- R4: Select codes 7 and above give a period of 10 core half-cycles, which is ratio 5, the same as code 6.
- R5: Each period begins with a low phase of ceil(P/2) half-cycles and ends with a high phase of floor(P/2) half-cycles, where P is the period length in half-cycles.
- R6: The first period after reset is released uses ratio 4 (8 half-cycles, 4 low then 4 high), whatever the select input shows. The output is low in the first half-cycle after release.
- R7: A change of the select code made during the first half-cycle of a period's low phase leaves that period at its old length and sets the length of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | Division code, synchronous to clk_core |
| mclk_out | output | NUM_OUT | Identical copies of the divided memory clock |

## Verification
A position counter or a latched length that goes wrong shows up as a low or high phase of the wrong duration. It appears at the ports within one output period, which is at most 10 core half-cycles. A fault in the two-edge combiner flips the level in alternate half-cycles, so the phase lengths are wrong from the first period after reset. A ratio that is latched too early or too late stretches or shrinks the period in which the select changed, not the one after it. A scoreboard that measures every phase in half-cycles therefore catches it in that same period.

// File: rtl/halfstep_clkdiv_pkg.sv
package halfstep_clkdiv_pkg;
  localparam int SEL_W    = 3;
  localparam int HALF_W   = 4;
  localparam int BASE_HALVES = 4;
  localparam int TOP_CODE = 6;

  typedef logic [HALF_W-1:0] halves_t;
  typedef logic [SEL_W-1:0]  sel_t;

  // Period length in core half-cycles for a select code.
  function automatic halves_t period_halves(input sel_t code);
    if (int'(code) > TOP_CODE) return halves_t'(BASE_HALVES + TOP_CODE);
    return halves_t'(BASE_HALVES + int'(code));
  endfunction

  // Half-cycles spent low at the start of a period.
  function automatic halves_t low_halves(input halves_t len);
    return halves_t'((len + 1'b1) >> 1);
  endfunction
endpackage

// File: rtl/halfstep_sched.sv
module halfstep_sched
  import halfstep_clkdiv_pkg::*;
#(
  parameter sel_t RESET_CODE = sel_t'(4)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  sel_t    ratio_sel,
  output logic    lvl_first,
  output logic    lvl_second,
  output halves_t pos_q,
  output halves_t len_q
);
  halves_t sel_len;
  halves_t p1, l1, p2, l2;

  assign sel_len = period_halves(ratio_sel);

  // Two half-cycle steps per core cycle; a wrap to position 0 loads the new length.
  always_comb begin
    if (halves_t'(pos_q + 1'b1) == len_q) begin
      p1 = '0;
      l1 = sel_len;
    end else begin
      p1 = halves_t'(pos_q + 1'b1);
      l1 = len_q;
    end
    if (halves_t'(p1 + 1'b1) == l1) begin
      p2 = '0;
      l2 = sel_len;
    end else begin
      p2 = halves_t'(p1 + 1'b1);
      l2 = l1;
    end
  end

  assign lvl_first  = (pos_q >= low_halves(len_q));
  assign lvl_second = (p1 >= low_halves(l1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= period_halves(RESET_CODE);
    end else begin
      pos_q <= p2;
      len_q <= l2;
    end
  end
endmodule

// File: rtl/dual_edge_gen.sv
module dual_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_first,
  input  logic lvl_second,
  output logic clk_out
);
  logic rise_q;
  logic hold_q;
  logic fall_q;

  // Rising-edge flop sets the first half; the falling-edge flop corrects the second.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      rise_q <= lvl_first ^ fall_q;
      hold_q <= lvl_second;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q ^ hold_q;
  end

  // Only one input changes per edge, so the XOR cannot glitch.
  assign clk_out = rise_q ^ fall_q;
endmodule

// File: rtl/halfstep_clkdiv.sv
module halfstep_clkdiv
  import halfstep_clkdiv_pkg::*;
#(
  parameter int   NUM_OUT    = 4,
  parameter sel_t RESET_CODE = sel_t'(4)
) (
  input  logic               clk_core,
  input  logic               rst_n,
  input  logic [2:0]         ratio_sel,
  output logic [NUM_OUT-1:0] mclk_out
);
  logic    lvl_first, lvl_second, div_clk;
  halves_t sched_pos, sched_len;

  halfstep_sched #(.RESET_CODE(RESET_CODE)) u_sched (
    .clk        (clk_core),
    .rst_n      (rst_n),
    .ratio_sel  (ratio_sel),
    .lvl_first  (lvl_first),
    .lvl_second (lvl_second),
    .pos_q      (sched_pos),
    .len_q      (sched_len)
  );

  dual_edge_gen u_gen (
    .clk        (clk_core),
    .rst_n      (rst_n),
    .lvl_first  (lvl_first),
    .lvl_second (lvl_second),
    .clk_out    (div_clk)
  );

  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_fanout
    assign mclk_out[gi] = div_clk;
  end
endmodule

// File: rtl/halfstep_clkdiv_chk.sv
module halfstep_clkdiv_chk
  import halfstep_clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input logic               clk_core,
  input logic               rst_n,
  input logic [2:0]         ratio_sel,
  input logic [NUM_OUT-1:0] mclk_out,
  input halves_t            sched_pos,
  input halves_t            sched_len
);
  always @(posedge clk_core) begin
    if (!rst_n) a_r1_low_in_reset: assert (mclk_out == '0);
  end

  a_r2_copies_rise: assert property (@(posedge clk_core) disable iff (!rst_n)
    mclk_out == {NUM_OUT{mclk_out[0]}});

  a_r2_copies_fall: assert property (@(negedge clk_core) disable iff (!rst_n)
    mclk_out == {NUM_OUT{mclk_out[0]}});

  a_r3_pos_in_range: assert property (@(posedge clk_core) disable iff (!rst_n)
    sched_pos < sched_len);

  a_r3_len_legal: assert property (@(posedge clk_core) disable iff (!rst_n)
    (sched_len >= 4'd4) && (sched_len <= 4'd10));

  a_r4_top_code: assert property (@(posedge clk_core) disable iff (!rst_n)
    ((sched_pos < $past(sched_pos)) && ($past(ratio_sel) == 3'd7)) |-> (sched_len == 4'd10));

  a_r6_start_low: assert property (@(posedge clk_core) disable iff (!rst_n)
    $rose(rst_n) |-> (mclk_out == '0));

  a_r7_len_at_boundary: assert property (@(posedge clk_core) disable iff (!rst_n)
    (sched_len != $past(sched_len)) |-> (sched_pos < $past(sched_pos)));
endmodule

bind halfstep_clkdiv halfstep_clkdiv_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk_core  (clk_core),
  .rst_n     (rst_n),
  .ratio_sel (ratio_sel),
  .mclk_out  (mclk_out),
  .sched_pos (sched_pos),
  .sched_len (sched_len)
);

// File: tb/halfstep_clkdiv_bench.sv
module halfstep_clkdiv_bench;
  localparam int NUM_OUT = 4;

  typedef struct {
    bit    lvl;
    int    len;
    string tag;
  } seg_t;

  logic               clk_core = 1'b0;
  logic               rst_n    = 1'b0;
  logic [2:0]         ratio_sel = 3'd0;
  logic [NUM_OUT-1:0] mclk_out;

  int   checks = 0;
  int   errors = 0;
  int   periods_started = 1;
  bit   stop_mon = 1'b0;
  bit   finished = 1'b0;
  seg_t sb_q[$];

  halfstep_clkdiv #(.NUM_OUT(NUM_OUT)) u_halfstep_clkdiv (
    .clk_core  (clk_core),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .mclk_out  (mclk_out)
  );

  always #10 clk_core = ~clk_core;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: pushes the two phases one period is expected to have.
  task automatic push_period(input int code, input string low_tag, input string high_tag);
    int n2;
    n2 = (code > 6) ? 10 : 4 + code;
    sb_q.push_back('{lvl: 1'b0, len: (n2 + 1) / 2, tag: low_tag});
    sb_q.push_back('{lvl: 1'b1, len: n2 / 2, tag: high_tag});
  endtask

  // Monitor: samples mid half-cycle, measures phase lengths, compares with the queue.
  initial begin
    bit cur_lvl;
    bit lvl;
    int run;
    seg_t exp_seg;
    wait (rst_n);
    @(posedge clk_core);
    #5;
    cur_lvl = 1'b0;
    run = 0;
    while (!stop_mon) begin
      lvl = mclk_out[0];
      check(mclk_out == {NUM_OUT{lvl}}, "R2 copies", int'(mclk_out), int'({NUM_OUT{lvl}}));
      if (lvl != cur_lvl) begin
        if (sb_q.size() > 0) begin
          exp_seg = sb_q.pop_front();
          check((exp_seg.lvl == cur_lvl) && (exp_seg.len == run),
                {exp_seg.tag, (cur_lvl ? " high phase" : " low phase")}, run, exp_seg.len);
        end
        if (!lvl) periods_started++;
        cur_lvl = lvl;
        run = 1;
      end else begin
        run++;
      end
      #10;
    end
  end

  initial begin
    int seq[8] = '{3, 0, 1, 6, 7, 2, 5, 4};
    ratio_sel = 3'(seq[0]);
    // R6: default period after reset, regardless of the select input.
    push_period(4, "R6", "R6");
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 3; j++) begin
        push_period(seq[i], (j == 0) ? "R7" : "R5", (seq[i] == 7) ? "R4" : "R3");
      end
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk_core);
    #5;
    check(mclk_out == '0, "R1 held in reset", int'(mclk_out), 0);
    @(negedge clk_core);
    #5;
    rst_n = 1'b1;
    for (int i = 0; i < 7; i++) begin
      wait (periods_started == 4 + 3 * i);
      ratio_sel = 3'(seq[i + 1]);
    end
    wait (sb_q.size() == 0);
    check(1'b1, "R5 queue drained", 0, 0);
    stop_mon = 1'b1;
    wait (mclk_out[0] == 1'b1);
    #1;
    rst_n = 1'b0;
    #1;
    check(mclk_out == '0, "R1 async reset", int'(mclk_out), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1-timeout actual=%0d expected=%0d", sb_q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule